// File: doc/BRIEF.md
# Byte-Granular Race Resolution Engine

When a thread leaves a critical section, every cache block it touched inside that section is held in a small side store. Each block carries six per-byte access vectors that record what this core and the other cores did to each byte. This engine visits the side-store entries one at a time, in index order. For each valid entry it fetches the newest copy of the block held outside the side store. That copy comes from main memory, or from the core that owns a modified copy. The engine then decides, for every byte, whether the value produced inside the section or the outside value must win, and writes the merged block back.

One byte pattern cannot be ordered into any serial schedule: both sides read the byte, then both write it. When any byte of an entry shows this pattern, the engine stops the pass without writing that entry back. It raises a sticky race error and records the block address together with a mask of the offending bytes. The bus is held locked for the whole pass. A one-cycle done pulse ends every pass. On a clean pass, a tracker-clear pulse accompanies the done pulse.

Top module: `rre_engine`

## Requirements
- R1: The fetch for an entry is directed to the owning core (`fetch_from_core_o`=1) when the entry's state field is 2'b10, and to main memory (`fetch_from_core_o`=0) for 2'b00 and 2'b01.
- R2: Entries are visited in ascending index order and invalid entries are skipped. Each valid entry gets exactly one fetch, at that entry's address, and then exactly one write-back at the same address. The two requests are never raised together, and the write-back data stays stable while it waits for its acknowledge.
- R3: For a byte whose vectors match none of the race rules R4 to R7, the written value is the local byte when the this-core write bit is 1, and the outside byte otherwise.
- R4: With this-core write=1, other-read=1 and other-write=0, the local byte is written, whatever the this-core read bit is.
- R5: With this-core read=0 and this-core write, other-read and other-write all 1, the local byte is written, whatever the other-first-read bit is.
- R6: With this-core read=1 and other-write=1, the outside byte is written unless both this-core write and other-read are 1. This holds whatever the first-access bits are.
- R7: With all four read/write bits at 1, the pair {this-first-read, other-first-read} selects the value: 00 writes the outside byte, 01 the local byte, and 10 the outside byte.
- R8: If any byte of a valid entry has all six bits set, that entry and the entries after it are not written back. `race_err_o` rises together with `done_o`, `err_addr_o` holds the entry's address, and `err_mask_o` has a 1 for each such byte.
- R9: `bus_lock_o` is 1 in every cycle from the one after `start_i` is sampled up to the cycle before the done pulse. It is 0 in the done cycle and after reset.
- R10: `done_o` is high for exactly one cycle. That cycle directly follows the acknowledge of the final write-back when the last entry is valid, or the fetch acknowledge of an aborted entry.
- R11: `clear_o` pulses together with `done_o` only at the end of a pass without an abort.
- R12: `race_err_o`, `err_addr_o` and `err_mask_o` keep their values after a pass until the next `start_i`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Critical-section exit; begins a pass |
| ent_idx_o | output | IDX_W | Side-store entry being read |
| ent_valid_i | input | 1 | Entry holds a block |
| ent_state_i | input | 2 | Outside state: 00 invalid, 01 shared-in-section, 10 modified-in-section |
| ent_addr_i | input | ADDR_W | Block address of the entry |
| ent_data_i | input | BYTES*8 | Locally held block value |
| ent_rt_i | input | BYTES | This-core read per byte |
| ent_wt_i | input | BYTES | This-core write per byte |
| ent_ro_i | input | BYTES | Other-core read per byte |
| ent_wo_i | input | BYTES | Other-core write per byte |
| ent_ftar_i | input | BYTES | This core's first access was a read |
| ent_foar_i | input | BYTES | Other cores' first access was a read |
| fetch_req_o | output | 1 | Outside-copy fetch request |
| fetch_addr_o | output | ADDR_W | Fetch address |
| fetch_from_core_o | output | 1 | 1: fetch from owning core, 0: from memory |
| fetch_ack_i | input | 1 | Fetch data valid |
| fetch_data_i | input | BYTES*8 | Outside block value |
| wb_req_o | output | 1 | Write-back request |
| wb_addr_o | output | ADDR_W | Write-back address |
| wb_data_o | output | BYTES*8 | Merged block |
| wb_ack_i | input | 1 | Write-back accepted |
| bus_lock_o | output | 1 | Bus held for the pass |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| clear_o | output | 1 | Tracker clear, clean passes only |
| race_err_o | output | 1 | Unserializable race seen in last pass |
| err_addr_o | output | ADDR_W | Address of the aborted entry |
| err_mask_o | output | BYTES | Offending bytes of the aborted entry |

## Verification
Two passes together put all 63 serializable values of the six access bits on separate bytes. Every local and outside byte differs, so any wrong per-byte choice shows up in the written data. A pass with invalid entries in the middle and at the end separates skipping from processing, and mixed state fields tell the memory source from the core source. A pass with one fatal byte in a middle entry checks the abort point, the address and mask capture, and that the error persists. A pass with no valid entries checks that the error clears and that a clean done pulse follows with no fetch at all. Acknowledge delays from zero to several cycles check that done and the requests line up with the handshakes.

// File: rtl/rre_pkg.sv
package rre_pkg;

    typedef enum logic [2:0] {
        RC_NONE,
        RC_WRW,
        RC_WRWX,
        RC_XWR,
        RC_RRWR,
        RC_RWW,
        RC_RRWW
    } race_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCAN,
        PH_FETCH,
        PH_WB,
        PH_DONE
    } phase_e;

    function automatic race_e classify(input logic rt, input logic wt,
                                       input logic ro, input logic wo,
                                       input logic ftar, input logic foar);
        race_e k;
        k = RC_NONE;
        if (!rt) begin
            if (wt && ro && !wo)      k = RC_WRW;
            else if (wt && ro && wo)  k = foar ? RC_WRWX : RC_NONE;
        end else if (!wt) begin
            if (wo)                   k = (ro && foar) ? RC_RRWR : RC_XWR;
        end else begin
            case ({ro, wo})
                2'b01:   k = RC_XWR;
                2'b10:   k = RC_WRW;
                2'b11: begin
                    case ({ftar, foar})
                        2'b00:   k = RC_XWR;
                        2'b01:   k = RC_WRWX;
                        2'b10:   k = RC_RWW;
                        default: k = RC_RRWW;
                    endcase
                end
                default: k = RC_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/rre_byte_judge.sv
module rre_byte_judge
    import rre_pkg::*;
(
    input  logic       rt,
    input  logic       wt,
    input  logic       ro,
    input  logic       wo,
    input  logic       ftar,
    input  logic       foar,
    input  logic [7:0] loc_byte,
    input  logic [7:0] out_byte,
    output logic [7:0] pick_byte,
    output logic       fatal
);

    race_e kind;

    always_comb begin
        kind  = classify(rt, wt, ro, wo, ftar, foar);
        fatal = (kind == RC_RRWW);
        case (kind)
            RC_WRW, RC_WRWX:                  pick_byte = loc_byte;
            RC_XWR, RC_RRWR, RC_RWW, RC_RRWW: pick_byte = out_byte;
            default:                          pick_byte = wt ? loc_byte : out_byte;
        endcase
    end

endmodule

// File: rtl/rre_merge.sv
module rre_merge #(
    parameter int BYTES = 8,
    localparam int DW   = BYTES * 8
) (
    input  logic [BYTES-1:0] rt,
    input  logic [BYTES-1:0] wt,
    input  logic [BYTES-1:0] ro,
    input  logic [BYTES-1:0] wo,
    input  logic [BYTES-1:0] ftar,
    input  logic [BYTES-1:0] foar,
    input  logic [DW-1:0]    loc_blk,
    input  logic [DW-1:0]    out_blk,
    output logic [DW-1:0]    merged,
    output logic [BYTES-1:0] fatal_mask
);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        rre_byte_judge u_judge (
            .rt        (rt[b]),
            .wt        (wt[b]),
            .ro        (ro[b]),
            .wo        (wo[b]),
            .ftar      (ftar[b]),
            .foar      (foar[b]),
            .loc_byte  (loc_blk[b*8 +: 8]),
            .out_byte  (out_blk[b*8 +: 8]),
            .pick_byte (merged[b*8 +: 8]),
            .fatal     (fatal_mask[b])
        );
    end

endmodule

// File: rtl/rre_engine.sv
module rre_engine
    import rre_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int BYTES   = 8,
    parameter int ADDR_W  = 16,
    localparam int DW     = BYTES * 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [IDX_W-1:0]  ent_idx_o,
    input  logic              ent_valid_i,
    input  logic [1:0]        ent_state_i,
    input  logic [ADDR_W-1:0] ent_addr_i,
    input  logic [DW-1:0]     ent_data_i,
    input  logic [BYTES-1:0]  ent_rt_i,
    input  logic [BYTES-1:0]  ent_wt_i,
    input  logic [BYTES-1:0]  ent_ro_i,
    input  logic [BYTES-1:0]  ent_wo_i,
    input  logic [BYTES-1:0]  ent_ftar_i,
    input  logic [BYTES-1:0]  ent_foar_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              fetch_from_core_o,
    input  logic              fetch_ack_i,
    input  logic [DW-1:0]     fetch_data_i,
    output logic              wb_req_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic [DW-1:0]     wb_data_o,
    input  logic              wb_ack_i,
    output logic              bus_lock_o,
    output logic              done_o,
    output logic              clear_o,
    output logic              race_err_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [BYTES-1:0]  err_mask_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic [DW-1:0]     wbdata;
        logic              err;
        logic [ADDR_W-1:0] err_addr;
        logic [BYTES-1:0]  err_mask;
    } eng_t;

    eng_t state_d, state_q;

    logic [DW-1:0]    merged;
    logic [BYTES-1:0] fatal_mask;

    // The tracker row selected by idx stays put while the bus is locked,
    // so the vectors are consumed straight from the read port.
    rre_merge #(.BYTES(BYTES)) u_merge (
        .rt         (ent_rt_i),
        .wt         (ent_wt_i),
        .ro         (ent_ro_i),
        .wo         (ent_wo_i),
        .ftar       (ent_ftar_i),
        .foar       (ent_foar_i),
        .loc_blk    (ent_data_i),
        .out_blk    (fetch_data_i),
        .merged     (merged),
        .fatal_mask (fatal_mask)
    );

    always_comb begin
        state_d = state_q;
        case (state_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    state_d.phase    = PH_SCAN;
                    state_d.idx      = '0;
                    state_d.err      = 1'b0;
                    state_d.err_addr = '0;
                    state_d.err_mask = '0;
                end
            end
            PH_SCAN: begin
                if (ent_valid_i)                 state_d.phase = PH_FETCH;
                else if (state_q.idx == LAST_IDX) state_d.phase = PH_DONE;
                else                             state_d.idx   = state_q.idx + 1'b1;
            end
            PH_FETCH: begin
                if (fetch_ack_i) begin
                    if (|fatal_mask) begin
                        state_d.err      = 1'b1;
                        state_d.err_addr = ent_addr_i;
                        state_d.err_mask = fatal_mask;
                        state_d.phase    = PH_DONE;
                    end else begin
                        state_d.wbdata   = merged;
                        state_d.phase    = PH_WB;
                    end
                end
            end
            PH_WB: begin
                if (wb_ack_i) begin
                    if (state_q.idx == LAST_IDX) begin
                        state_d.phase = PH_DONE;
                    end else begin
                        state_d.idx   = state_q.idx + 1'b1;
                        state_d.phase = PH_SCAN;
                    end
                end
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ent_idx_o         = state_q.idx;
    assign fetch_req_o       = (state_q.phase == PH_FETCH);
    assign fetch_addr_o      = ent_addr_i;
    assign fetch_from_core_o = (ent_state_i == 2'b10);
    assign wb_req_o          = (state_q.phase == PH_WB);
    assign wb_addr_o         = ent_addr_i;
    assign wb_data_o         = state_q.wbdata;
    assign bus_lock_o        = (state_q.phase == PH_SCAN) || (state_q.phase == PH_FETCH)
                             || (state_q.phase == PH_WB);
    assign done_o            = (state_q.phase == PH_DONE);
    assign clear_o           = done_o && !state_q.err;
    assign race_err_o        = state_q.err;
    assign err_addr_o        = state_q.err_addr;
    assign err_mask_o        = state_q.err_mask;

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req_o && wb_req_o)); // R2
    AST_WB_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && !wb_ack_i) |=> $stable(wb_data_o)); // R2
    AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o || wb_req_o) |-> bus_lock_o); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(race_err_o) |-> done_o); // R8
    AST_CLEAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> (done_o && !race_err_o)); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (race_err_o && !start_i) |=> race_err_o); // R12

endmodule

// File: tb/rre_engine_bench.sv
module rre_engine_bench;

    localparam int ENTRIES = 4;
    localparam int BYTES   = 8;
    localparam int ADDR_W  = 16;
    localparam int DW      = BYTES * 8;
    localparam int IDX_W   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    always #2 clk = ~clk;

    logic [IDX_W-1:0]  ent_idx_o;
    logic              ent_valid_i;
    logic [1:0]        ent_state_i;
    logic [ADDR_W-1:0] ent_addr_i;
    logic [DW-1:0]     ent_data_i;
    logic [BYTES-1:0]  ent_rt_i, ent_wt_i, ent_ro_i, ent_wo_i, ent_ftar_i, ent_foar_i;
    logic              fetch_req_o, fetch_from_core_o;
    logic [ADDR_W-1:0] fetch_addr_o, wb_addr_o, err_addr_o;
    logic              fetch_ack_i = 1'b0;
    logic [DW-1:0]     fetch_data_i = '0;
    logic              wb_req_o;
    logic [DW-1:0]     wb_data_o;
    logic              wb_ack_i = 1'b0;
    logic              bus_lock_o, done_o, clear_o, race_err_o;
    logic [BYTES-1:0]  err_mask_o;

    // tracker model
    logic              t_valid [ENTRIES];
    logic [1:0]        t_state [ENTRIES];
    logic [ADDR_W-1:0] t_addr  [ENTRIES];
    logic [DW-1:0]     t_loc   [ENTRIES];
    logic [DW-1:0]     t_out   [ENTRIES];
    logic [5:0]        t_combo [ENTRIES][BYTES];

    always_comb begin
        ent_valid_i = t_valid[ent_idx_o];
        ent_state_i = t_state[ent_idx_o];
        ent_addr_i  = t_addr[ent_idx_o];
        ent_data_i  = t_loc[ent_idx_o];
        for (int b = 0; b < BYTES; b++) begin
            ent_rt_i[b]   = t_combo[ent_idx_o][b][5];
            ent_wt_i[b]   = t_combo[ent_idx_o][b][4];
            ent_ro_i[b]   = t_combo[ent_idx_o][b][3];
            ent_wo_i[b]   = t_combo[ent_idx_o][b][2];
            ent_ftar_i[b] = t_combo[ent_idx_o][b][1];
            ent_foar_i[b] = t_combo[ent_idx_o][b][0];
        end
    end

    rre_engine #(.ENTRIES(ENTRIES), .BYTES(BYTES), .ADDR_W(ADDR_W)) u_rre_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ent_idx_o(ent_idx_o),
        .ent_valid_i(ent_valid_i), .ent_state_i(ent_state_i), .ent_addr_i(ent_addr_i),
        .ent_data_i(ent_data_i), .ent_rt_i(ent_rt_i), .ent_wt_i(ent_wt_i),
        .ent_ro_i(ent_ro_i), .ent_wo_i(ent_wo_i), .ent_ftar_i(ent_ftar_i),
        .ent_foar_i(ent_foar_i), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_from_core_o(fetch_from_core_o), .fetch_ack_i(fetch_ack_i),
        .fetch_data_i(fetch_data_i), .wb_req_o(wb_req_o), .wb_addr_o(wb_addr_o),
        .wb_data_o(wb_data_o), .wb_ack_i(wb_ack_i), .bus_lock_o(bus_lock_o),
        .done_o(done_o), .clear_o(clear_o), .race_err_o(race_err_o),
        .err_addr_o(err_addr_o), .err_mask_o(err_mask_o)
    );

    int compared = 0;
    int mism = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mism++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference decision: 1 = local byte wins
    function automatic bit ref_pick(input logic [5:0] c, output string tag);
        logic rt, wt, ro, wo, ftar, foar;
        {rt, wt, ro, wo, ftar, foar} = c;
        if (rt && wt && ro && wo) begin tag = "R7"; return (!ftar && foar); end
        if (!rt && wt && ro && wo) begin tag = "R5"; return 1'b1; end
        if (rt && wo)              begin tag = "R6"; return 1'b0; end
        if (wt && ro && !wo)       begin tag = "R4"; return 1'b1; end
        tag = "R3";
        return wt;
    endfunction

    // expectations
    logic [ADDR_W-1:0] q_faddr[$];
    logic              q_fsrc[$];
    logic [ADDR_W-1:0] q_waddr[$];
    logic [DW-1:0]     q_wdata[$];
    int                q_wentry[$];
    logic              x_err;
    logic [ADDR_W-1:0] x_err_addr;
    logic [BYTES-1:0]  x_err_mask;
    logic              tight;
    logic              pass_active = 1'b0;
    logic              expect_done = 1'b0;
    logic              after_done  = 1'b0;
    int fi, wi, fdly, wdly, fcnt, wcnt;

    task automatic plan_pass();
        int last;
        q_faddr.delete(); q_fsrc.delete(); q_waddr.delete(); q_wdata.delete(); q_wentry.delete();
        x_err = 1'b0; x_err_addr = '0; x_err_mask = '0; last = -1;
        for (int e = 0; e < ENTRIES; e++) begin
            logic [DW-1:0]    m;
            logic [BYTES-1:0] fm;
            if (!t_valid[e]) continue;
            q_faddr.push_back(t_addr[e]);
            q_fsrc.push_back(t_state[e] == 2'b10);
            fm = '0;
            for (int b = 0; b < BYTES; b++) begin
                string tg;
                m[b*8 +: 8] = ref_pick(t_combo[e][b], tg) ? t_loc[e][b*8 +: 8] : t_out[e][b*8 +: 8];
                if (t_combo[e][b] == 6'h3f) fm[b] = 1'b1;
            end
            if (fm != '0) begin
                x_err = 1'b1; x_err_addr = t_addr[e]; x_err_mask = fm;
                break;
            end
            q_waddr.push_back(t_addr[e]);
            q_wdata.push_back(m);
            q_wentry.push_back(e);
            last = e;
        end
        tight = x_err || (last == ENTRIES - 1);
    endtask

    task automatic run_pass(input int fd, input int wd);
        plan_pass();
        fdly = fd; wdly = wd; fi = 0; wi = 0; fcnt = 0; wcnt = 0;
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0; pass_active = 1'b1;
        while (pass_active) @(posedge clk);
        repeat (2) @(posedge clk);
        chk("R2", "fetch count", 64'(fi), 64'(q_faddr.size()));
        chk("R2", "write-back count", 64'(wi), 64'(q_waddr.size()));
    endtask

    task automatic set_entry(input int e, input logic v, input logic [1:0] st,
                             input logic [ADDR_W-1:0] a);
        t_valid[e] = v; t_state[e] = st; t_addr[e] = a;
        for (int b = 0; b < BYTES; b++) begin
            t_loc[e][b*8 +: 8] = 8'(8'h10 * e + b + 8'h01);
            t_out[e][b*8 +: 8] = 8'(8'h80 + 8'h10 * e + b);
        end
    endtask

    // monitor and responders, sampled away from the active edge
    always @(negedge clk) begin
        if (after_done) begin
            chk("R10", "done width", 64'(done_o), 64'd0);
            after_done = 1'b0;
        end
        if (expect_done) begin
            chk("R10", "done timing", 64'(done_o), 64'd1);
            expect_done = 1'b0;
        end
        if (pass_active) begin
            if (done_o) begin
                chk("R9", "lock at done", 64'(bus_lock_o), 64'd0);
                chk("R8", "race_err", 64'(race_err_o), 64'(x_err));
                if (x_err) begin
                    chk("R8", "err_addr", 64'(err_addr_o), 64'(x_err_addr));
                    chk("R8", "err_mask", 64'(err_mask_o), 64'(x_err_mask));
                end
                chk("R11", "clear", 64'(clear_o), 64'(!x_err));
                pass_active = 1'b0;
                after_done  = 1'b1;
            end else begin
                chk("R9", "lock in pass", 64'(bus_lock_o), 64'd1);
                chk("R11", "clear in pass", 64'(clear_o), 64'd0);
            end
        end
        if (fetch_ack_i) fetch_ack_i = 1'b0;
        else if (fetch_req_o) begin
            if (fcnt >= fdly) begin
                fcnt = 0;
                fetch_ack_i  = 1'b1;
                fetch_data_i = t_out[ent_idx_o];
                if (fi < q_faddr.size()) begin
                    chk("R2", "fetch addr", 64'(fetch_addr_o), 64'(q_faddr[fi]));
                    chk("R1", "fetch source", 64'(fetch_from_core_o), 64'(q_fsrc[fi]));
                    if (x_err && fi == q_faddr.size() - 1) expect_done = 1'b1;
                end else begin
                    compared++; mism++;
                    $display("FAIL R2 unexpected fetch actual=%h expected=none", fetch_addr_o);
                end
                fi++;
            end else fcnt++;
        end
        if (wb_ack_i) wb_ack_i = 1'b0;
        else if (wb_req_o) begin
            if (wcnt >= wdly) begin
                wcnt = 0;
                wb_ack_i = 1'b1;
                if (wi < q_waddr.size()) begin
                    int e;
                    e = q_wentry[wi];
                    chk("R2", "wb addr", 64'(wb_addr_o), 64'(q_waddr[wi]));
                    for (int b = 0; b < BYTES; b++) begin
                        string tg;
                        void'(ref_pick(t_combo[e][b], tg));
                        chk(tg, $sformatf("byte e%0d b%0d combo %02h", e, b, t_combo[e][b]),
                            64'(wb_data_o[b*8 +: 8]), 64'(q_wdata[wi][b*8 +: 8]));
                    end
                    if (tight && !x_err && wi == q_waddr.size() - 1) expect_done = 1'b1;
                end else begin
                    compared++; mism++;
                    $display("FAIL R2 unexpected write-back actual=%h expected=none", wb_addr_o);
                end
                wi++;
            end else wcnt++;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        compared++; mism++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

    initial begin
        for (int e = 0; e < ENTRIES; e++) begin
            set_entry(e, 1'b0, 2'b00, '0);
            for (int b = 0; b < BYTES; b++) t_combo[e][b] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset lock", 64'(bus_lock_o), 64'd0);
        chk("R10", "reset done", 64'(done_o), 64'd0);
        chk("R2", "reset requests", 64'({fetch_req_o, wb_req_o}), 64'd0);
        chk("R8", "reset race_err", 64'(race_err_o), 64'd0);
        chk("R11", "reset clear", 64'(clear_o), 64'd0);

        // S1: combos 0..31, every state code
        for (int e = 0; e < ENTRIES; e++) begin
            set_entry(e, 1'b1, 2'(e), 16'h1000 + 16'(e * 16));
            for (int b = 0; b < BYTES; b++) t_combo[e][b] = 6'(e * BYTES + b);
        end
        run_pass(0, 0);

        // S2: combos 32..62, slower handshakes
        for (int e = 0; e < ENTRIES; e++) begin
            set_entry(e, 1'b1, (e % 2 == 0) ? 2'b10 : 2'b01, 16'h2000 + 16'(e * 16));
            for (int b = 0; b < BYTES; b++) begin
                int c;
                c = 32 + e * BYTES + b;
                t_combo[e][b] = (c == 63) ? 6'd0 : 6'(c);
            end
        end
        run_pass(2, 1);

        // S3: invalid entries in the middle and at the end
        for (int e = 0; e < ENTRIES; e++) begin
            set_entry(e, (e % 2 == 0), (e == 2) ? 2'b10 : 2'b00, 16'h3000 + 16'(e * 16));
            for (int b = 0; b < BYTES; b++) t_combo[e][b] = 6'((e * 13 + b * 7) % 63);
        end
        run_pass(1, 3);

        // S4: fatal byte in entry 2 aborts the pass
        for (int e = 0; e < ENTRIES; e++) begin
            set_entry(e, 1'b1, 2'b01, 16'h4000 + 16'(e * 16));
            for (int b = 0; b < BYTES; b++) t_combo[e][b] = 6'((e * 5 + b * 11) % 63);
        end
        t_combo[2][5] = 6'h3f;
        t_combo[2][1] = 6'h3f;
        run_pass(0, 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "race_err held", 64'(race_err_o), 64'd1);
        chk("R12", "err_addr held", 64'(err_addr_o), 64'h4020);
        chk("R12", "err_mask held", 64'(err_mask_o), 64'h22);

        // S5: no valid entries; error cleared by the new pass
        for (int e = 0; e < ENTRIES; e++) t_valid[e] = 1'b0;
        run_pass(0, 0);
        chk("R12", "race_err cleared", 64'(race_err_o), 64'd0);
        chk("R12", "err_mask cleared", 64'(err_mask_o), 64'd0);

        // S6: fatal in the first entry, fetched from an owning core
        set_entry(0, 1'b1, 2'b10, 16'h5000);
        for (int b = 0; b < BYTES; b++) t_combo[0][b] = 6'h3f;
        set_entry(3, 1'b1, 2'b00, 16'h5030);
        run_pass(3, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

endmodule